// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Management Bus

This block is the control-register slave of a multi-output clock fanout device. It watches a two-wire management bus (SMBus, up to 100 kHz) through a pair of synchronising filters. It answers on a 7-bit address picked by three strap pins and serves a ten-entry byte register file. A host moves data in indexed blocks. A write names a starting index and a byte count, then streams that many bytes into consecutive registers. A read names the index, issues a repeated start with the read address, and receives a byte-count prefix taken from a writable register, followed by consecutive register bytes until the host declines one.

The register file holds three groups of per-output enable bits, a loop-bandwidth select bit, a PLL-use bit, two bytes of live readback taken from input pins, an identity byte, a mixed revision/vendor byte and the writable readback-count byte. The enable and mode bits leave the block as registered control outputs. The data line is modelled as an open-drain pull-down enable. The whole interface stays silent while the reference clock is reported absent.

Top module: `smbus_ctrl_regs`

## Requirements
- R1: The write address is 8'hD0 + 2*strap_sel and the read address is that value plus one. A byte carrying any other address gets no acknowledge, and the slave keeps the data line released until the next start.
- R2: In a write (start, write address, index N, count X, data), every one of the first X data bytes is acknowledged and lands in register N+k. Each byte is applied one byte at a time.
- R3: Data bytes beyond the announced count X are not acknowledged and change no register.
- R4: After a repeated start with the read address, the first byte sent is register 7, the readback count. It is followed by registers N, N+1, … in order until the host answers a byte with NACK.
- R5: Reset values read as: register 1 = 8'hFF, 2 = 8'hFF, 5 = 8'h01 (revision 4'h0 in bits 7:4, vendor 4'h1 in bits 3:0), 6 = 8'hC2, 7 = 8'h07, 8 = 8'h1F, 0 and 9 = 8'h00.
- R6: Registers 0, 3, 4, 5, 6 and 9 and bits 7:5 of register 8 ignore writes. Register 8 bits 7:5 always read 0.
- R7: Register 3 returns rb_lo and register 4 returns rb_hi with bit 5 forced to 0, both as sampled when the byte is loaded for sending.
- R8: An index of 10 or above reads as 8'h00. Data written there is acknowledged and discarded, and the index keeps incrementing.
- R9: While ref_clk_ok is low, no byte is acknowledged and no register changes.
- R10: A stop ends a transfer at once and keeps bytes already written. A start at any point begins a fresh address phase.
- R11: oe_ctl bits 7:0 come from register 1, bits 13:8 from register 2 bits 5:0, and bits 18:14 from register 8 bits 4:0 (1 = output driving, 0 = high impedance). bw_low is register 2 bit 7 and pll_on is register 2 bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_ok | input | 1 | High while the reference clock runs; low silences the bus |
| strap_sel | input | 3 | Address strap value |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls the data line low |
| rb_lo | input | 8 | Live readback pins returned in register 3 |
| rb_hi | input | 8 | Live readback pins returned in register 4 (bit 5 unused) |
| oe_ctl | output | 19 | Per-output enables |
| bw_low | output | 1 | Loop bandwidth select, 1 = low |
| pll_on | output | 1 | 1 = PLL used, 0 = bypass |

## Verification
The assertions assume that every bus line level is held for several system clocks. They also assume that the data line moves only while the clock line is low, except at start and stop, and that consecutive data bytes are many cycles apart, so at most one register write is pending. The bench drives the bus with ten-cycle half periods and changes the data line a quarter period after the clock falls. It also samples the slave's acknowledge and data bits in the middle of the high phase, which keeps every stimulus inside those assumptions.

// File: rtl/smbrs_pkg.sv
package smbrs_pkg;

  localparam int BYTE_W   = 8;
  localparam int BCNT_W   = $clog2(BYTE_W + 1);
  localparam int NUM_REGS = 10;

  // register positions that the output mapping and readback depend on
  localparam int REG_OE_A   = 1;
  localparam int REG_OE_B   = 2;
  localparam int REG_RB_LO  = 3;
  localparam int REG_RB_HI  = 4;
  localparam int REG_IDMIX  = 5;
  localparam int REG_DEVID  = 6;
  localparam int REG_BCNT   = 7;
  localparam int REG_OE_C   = 8;

  localparam int OE_A_W  = 8;
  localparam int OE_B_W  = 6;
  localparam int OE_C_W  = 5;
  localparam int NUM_OUT = OE_A_W + OE_B_W + OE_C_W;

  localparam logic [6:0] BASE_ADDR7 = 7'h68;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK, S_HOLD
  } bus_st_t;

  typedef enum logic [1:0] {
    K_ADDR, K_INDEX, K_COUNT, K_DATA
  } rx_kind_t;

  function automatic logic [BYTE_W-1:0] wmask(int i);
    case (i)
      REG_OE_A, REG_OE_B, REG_BCNT: return 8'hFF;
      REG_OE_C:                     return 8'((1 << OE_C_W) - 1);
      default:                      return 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] rstval(int i);
    case (i)
      REG_OE_A, REG_OE_B: return 8'hFF;
      REG_BCNT:           return 8'h07;
      REG_OE_C:           return 8'((1 << OE_C_W) - 1);
      default:            return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbrs_filt.sv
module smbrs_filt #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic level_prev
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign level      = pipe[STAGES-1];
  assign level_prev = pipe[STAGES];
endmodule

// File: rtl/smbrs_regfile.sv
module smbrs_regfile
  import smbrs_pkg::*;
#(
  parameter int          N_REGS = NUM_REGS,
  parameter logic [3:0]  REV_ID = 4'h0,
  parameter logic [3:0]  VEN_ID = 4'h1,
  parameter logic [7:0]  DEV_ID = 8'hC2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [BYTE_W-1:0]             wr_idx,
  input  logic [BYTE_W-1:0]             wr_data,
  input  logic [BYTE_W-1:0]             rd_idx,
  input  logic [BYTE_W-1:0]             rb_lo,
  input  logic [BYTE_W-1:0]             rb_hi,
  output logic [BYTE_W-1:0]             rd_data,
  output logic [N_REGS-1:0][BYTE_W-1:0] regs_q
);
  localparam logic [BYTE_W-1:0] RB_HI_MASK = 8'hDF;

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] M  = wmask(g);
    localparam logic [BYTE_W-1:0] RV = rstval(g);
    if (M != '0) begin : g_rw
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= RV;
        else if (wr_en && wr_idx == BYTE_W'(g))
          q <= (wr_data & M) | (q & ~M);
      end
      assign regs_q[g] = q;
    end else begin : g_ro
      assign regs_q[g] = RV;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_REGS; i++)
      if (rd_idx == BYTE_W'(i)) rd_data = regs_q[i];
    if (rd_idx == BYTE_W'(REG_RB_LO)) rd_data = rb_lo;
    if (rd_idx == BYTE_W'(REG_RB_HI)) rd_data = rb_hi & RB_HI_MASK;
    if (rd_idx == BYTE_W'(REG_IDMIX)) rd_data = {REV_ID, VEN_ID};
    if (rd_idx == BYTE_W'(REG_DEVID)) rd_data = DEV_ID;
  end

  // output group A only moves on a write aimed at it
  p_oe_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == BYTE_W'(REG_OE_A)) |=> $stable(regs_q[REG_OE_A]));

  // the count register only moves on a write aimed at it
  p_bcnt_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == BYTE_W'(REG_BCNT)) |=> $stable(regs_q[REG_BCNT]));
endmodule

// File: rtl/smbrs_engine.sv
module smbrs_engine
  import smbrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic [BYTE_W-1:0] bc_value,
  output logic [BYTE_W-1:0] idx_q,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam logic [BCNT_W-1:0] FULL = BCNT_W'(BYTE_W);

  bus_st_t           state;
  rx_kind_t          kind;
  logic [BCNT_W-1:0] bitcnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] remain;
  logic              reading;
  logic              got_ack;

  always_ff @(posedge clk) begin
    if (rst || !bus_en) begin
      state   <= S_IDLE;
      kind    <= K_ADDR;
      bitcnt  <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      remain  <= '0;
      reading <= 1'b0;
      got_ack <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      if (rst) idx_q <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        state  <= S_RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise && bitcnt < FULL) begin
              rx_sh  <= {rx_sh[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              bitcnt <= '0;
              case (kind)
                K_ADDR: begin
                  if (rx_sh[BYTE_W-1:1] == dev_addr) begin
                    reading <= rx_sh[0];
                    kind    <= K_INDEX;
                    sda_oe  <= 1'b1;
                    state   <= S_RXACK;
                  end else begin
                    state <= S_HOLD;
                  end
                end
                K_INDEX: begin
                  idx_q  <= rx_sh;
                  kind   <= K_COUNT;
                  sda_oe <= 1'b1;
                  state  <= S_RXACK;
                end
                K_COUNT: begin
                  remain <= rx_sh;
                  kind   <= K_DATA;
                  sda_oe <= 1'b1;
                  state  <= S_RXACK;
                end
                default: begin
                  if (remain != '0) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= idx_q;
                    wr_data <= rx_sh;
                    idx_q   <= idx_q + 1'b1;
                    remain  <= remain - 1'b1;
                    sda_oe  <= 1'b1;
                    state   <= S_RXACK;
                  end else begin
                    state <= S_HOLD;
                  end
                end
              endcase
            end
          end
          S_RXACK: begin
            if (scl_fall) begin
              if (reading) begin
                tx_sh   <= bc_value;
                sda_oe  <= ~bc_value[BYTE_W-1];
                bitcnt  <= BCNT_W'(1);
                reading <= 1'b0;
                state   <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bitcnt < FULL) begin
                sda_oe <= ~tx_sh[BYTE_W-2];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
              end else begin
                sda_oe  <= 1'b0;
                got_ack <= 1'b0;
                state   <= S_TXACK;
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              got_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (got_ack) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                idx_q  <= idx_q + 1'b1;
                bitcnt <= BCNT_W'(1);
                state  <= S_TX;
              end else begin
                state <= S_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // the pull-down only engages while the bus clock is low
  p_drive_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s));

  // an absent reference clock silences the line and blocks writes
  p_clk_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> (!sda_oe && !wr_en));

  // a declined or foreign byte leaves the line released
  p_hold_release_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_HOLD) |-> !sda_oe);

  // each stored byte advances the index by exactly one
  p_idx_step_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (idx_q == wr_idx + 1'b1));

  // a write request is a single-cycle pulse per byte
  p_wr_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // a start always reopens the address phase
  p_start_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (start_ev && bus_en) |=> (state == S_RX && bitcnt == '0 && !sda_oe));
endmodule

// File: rtl/smbus_ctrl_regs.sv
module smbus_ctrl_regs
  import smbrs_pkg::*;
#(
  parameter int         FILT_STAGES = 2,
  parameter logic [3:0] REV_ID      = 4'h0,
  parameter logic [3:0] VEN_ID      = 4'h1,
  parameter logic [7:0] DEV_ID      = 8'hC2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_clk_ok,
  input  logic [2:0]         strap_sel,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull,
  input  logic [BYTE_W-1:0]  rb_lo,
  input  logic [BYTE_W-1:0]  rb_hi,
  output logic [NUM_OUT-1:0] oe_ctl,
  output logic               bw_low,
  output logic               pll_on
);
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic [6:0] dev_addr;
  logic [BYTE_W-1:0] idx_q, wr_idx, wr_data, rd_data;
  logic wr_en;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;

  smbrs_filt #(.STAGES(FILT_STAGES)) u_scl_filt (
    .clk(clk), .rst(rst), .din(scl_in), .level(scl_s), .level_prev(scl_p));
  smbrs_filt #(.STAGES(FILT_STAGES)) u_sda_filt (
    .clk(clk), .rst(rst), .din(sda_in), .level(sda_s), .level_prev(sda_p));

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  assign dev_addr = BASE_ADDR7 + {4'b0000, strap_sel};

  smbrs_engine u_engine (
    .clk(clk), .rst(rst), .bus_en(ref_clk_ok),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .dev_addr(dev_addr),
    .rd_data(rd_data), .bc_value(regs_q[REG_BCNT]),
    .idx_q(idx_q), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_oe(sda_pull));

  smbrs_regfile #(
    .N_REGS(NUM_REGS), .REV_ID(REV_ID), .VEN_ID(VEN_ID), .DEV_ID(DEV_ID)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(idx_q), .rb_lo(rb_lo), .rb_hi(rb_hi), .rd_data(rd_data),
    .regs_q(regs_q));

  assign oe_ctl = {regs_q[REG_OE_C][OE_C_W-1:0],
                   regs_q[REG_OE_B][OE_B_W-1:0],
                   regs_q[REG_OE_A][OE_A_W-1:0]};
  assign bw_low = regs_q[REG_OE_B][7];
  assign pll_on = regs_q[REG_OE_B][6];

  // the enable outputs only change one cycle after a register write
  p_oe_write_only_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(oe_ctl));
endmodule

// File: tb/test_smbus_ctrl_regs.sv
module test_smbus_ctrl_regs;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, ref_ok = 1'b1;
  logic [2:0] strap = 3'd6;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic [7:0] rb_lo = 8'hA6, rb_hi = 8'h7F;
  logic sda_pull, bw_low, pll_on;
  logic [18:0] oe_ctl;
  wire sda_bus = host_sda & ~sda_pull;

  smbus_ctrl_regs i_smbus_ctrl_regs (
    .clk(clk), .rst(rst), .ref_clk_ok(ref_ok), .strap_sel(strap),
    .scl_in(host_scl), .sda_in(sda_bus), .sda_pull(sda_pull),
    .rb_lo(rb_lo), .rb_hi(rb_hi), .oe_ctl(oe_ctl), .bw_low(bw_low),
    .pll_on(pll_on));

  int checks = 0, errors = 0;
  logic [7:0] wbuf[16], rbuf[16], mdl[10];
  logic ackv[16];
  logic aack, bc;
  logic [7:0] bcv;

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] msk(int i);
    case (i) 1, 2, 7: return 8'hFF; 8: return 8'h1F; default: return 8'h00; endcase
  endfunction

  function automatic logic [7:0] exp_rd(int i);
    if (i == 3) return rb_lo;
    if (i == 4) return rb_hi & 8'hDF;
    if (i == 5) return 8'h01;
    if (i == 6) return 8'hC2;
    if (i < 10) return mdl[i];
    return 8'h00;
  endfunction

  task automatic bstart();
    host_sda = 1'b1; tick(5); host_scl = 1'b1; tick(10);
    host_sda = 1'b0; tick(10); host_scl = 1'b0; tick(5);
  endtask

  task automatic bstop();
    host_sda = 1'b0; tick(5); host_scl = 1'b1; tick(10);
    host_sda = 1'b1; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; tick(5); host_scl = 1'b1; tick(10); host_scl = 1'b0; tick(5);
    end
    host_sda = 1'b1; tick(5); host_scl = 1'b1; tick(5);
    ack = ~sda_bus; tick(5); host_scl = 1'b0; tick(5);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(5); host_scl = 1'b1; tick(5); b[i] = sda_bus; tick(5); host_scl = 1'b0; tick(5);
    end
    host_sda = nack; tick(5); host_scl = 1'b1; tick(10); host_scl = 1'b0; tick(5);
    host_sda = 1'b1;
  endtask

  function automatic logic [7:0] waddr(); return {7'h68 + {4'd0, strap}, 1'b0}; endfunction

  task automatic blk_write(input int idx, input int cnt, input int nsend);
    logic a;
    bstart(); send_byte(waddr(), aack);
    send_byte(8'(idx), a); send_byte(8'(cnt), a);
    for (int i = 0; i < nsend; i++) send_byte(wbuf[i], ackv[i]);
    bstop();
  endtask

  task automatic model_write(input int idx, input int cnt, input int nsend);
    for (int i = 0; i < nsend && i < cnt; i++)
      if (idx + i < 10) mdl[idx+i] = (mdl[idx+i] & ~msk(idx+i)) | (wbuf[i] & msk(idx+i));
  endtask

  task automatic blk_read(input int idx, input int n);
    logic a;
    bstart(); send_byte(waddr(), a); send_byte(8'(idx), a);
    bstart(); send_byte(waddr() | 8'h01, aack);
    recv_byte(n == 0, bcv);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
    bstop();
  endtask

  task automatic check_all(string req);
    blk_read(0, 10);
    chk("R4", "count prefix", bcv, mdl[7]);
    for (int i = 0; i < 10; i++) chk(req, $sformatf("reg %0d", i), rbuf[i], exp_rd(i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 10; i++) mdl[i] = 8'h00;
    mdl[1] = 8'hFF; mdl[2] = 8'hFF; mdl[7] = 8'h07; mdl[8] = 8'h1F;
    tick(10); rst = 1'b0; tick(10);

    // R5 R11: reset state at the ports and through a read
    chk("R11", "oe_ctl reset", oe_ctl, 19'h7FFFF);
    chk("R11", "bw_low reset", bw_low, 1);
    chk("R11", "pll_on reset", pll_on, 1);
    chk("R1", "line idle", sda_pull, 0);
    check_all("R5");

    // R2 R11: two-byte write into the enable groups
    wbuf[0] = 8'h5A; wbuf[1] = 8'h3C;
    blk_write(1, 2, 2); model_write(1, 2, 2);
    chk("R2", "addr ack", aack, 1);
    chk("R2", "data ack 0", ackv[0], 1);
    chk("R2", "data ack 1", ackv[1], 1);
    tick(4);
    chk("R11", "oe_ctl map", oe_ctl, {mdl[8][4:0], mdl[2][5:0], mdl[1]});
    chk("R11", "bw_low", bw_low, mdl[2][7]);
    chk("R11", "pll_on", pll_on, mdl[2][6]);

    // R3: byte beyond count is declined
    wbuf[0] = 8'h0A; wbuf[1] = 8'h99;
    blk_write(7, 1, 2); model_write(7, 1, 2);
    chk("R3", "in-count ack", ackv[0], 1);
    chk("R3", "extra byte nack", ackv[1], 0);

    // R6: read-only and reserved targets
    wbuf[0] = 8'hFF; blk_write(0, 1, 1);
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hFF;
    blk_write(3, 4, 4);
    wbuf[0] = 8'hE5; wbuf[1] = 8'hFF; blk_write(8, 2, 2); model_write(8, 2, 2);
    check_all("R6");

    // R8: index beyond the file
    wbuf[0] = 8'h33; wbuf[1] = 8'h44; blk_write(12, 2, 2);
    chk("R8", "high index ack", ackv[1], 1);
    check_all("R8");
    blk_read(8, 4);
    for (int i = 0; i < 4; i++) chk("R8", $sformatf("read idx %0d", 8 + i), rbuf[i], exp_rd(8 + i));

    // R7: live readback patterns
    for (int p = 0; p < 4; p++) begin
      rb_lo = 8'h96 ^ 8'(p * 8'h35); rb_hi = 8'h69 ^ 8'(p * 8'h5B);
      blk_read(3, 2);
      chk("R7", "reg3 live", rbuf[0], exp_rd(3));
      chk("R7", "reg4 live", rbuf[1], exp_rd(4));
    end

    // R1: every strap against every address slot
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 8; a++) begin
        bstart(); send_byte({7'h68 + 7'(a), 1'b0}, aack);
        chk("R1", $sformatf("strap %0d addr %0d ack", s, a), aack, a == s);
        chk("R1", "line released", sda_pull, 0);
        bstop();
      end
    end
    strap = 3'd6;

    // R9: no reference clock
    ref_ok = 1'b0;
    wbuf[0] = 8'h00; blk_write(1, 1, 1);
    chk("R9", "addr ack absent", aack, 0);
    chk("R9", "data ack absent", ackv[0], 0);
    ref_ok = 1'b1; tick(4);
    chk("R9", "oe unchanged", oe_ctl, {mdl[8][4:0], mdl[2][5:0], mdl[1]});

    // R10: stop mid-transfer keeps written bytes; restart mid-transfer
    begin
      logic a;
      bstart(); send_byte(waddr(), a); send_byte(8'd2, a); send_byte(8'd3, a);
      send_byte(8'h11, a); bstop();
      mdl[2] = 8'h11;
      bstart(); send_byte(waddr(), a); send_byte(8'd5, a);
      bstart(); send_byte(waddr(), a);
      chk("R10", "restart addr ack", a, 1);
      send_byte(8'd1, a); send_byte(8'd1, a); send_byte(8'hA5, a); bstop();
      mdl[1] = 8'hA5;
      tick(4);
      chk("R10", "oe after abort", oe_ctl, {mdl[8][4:0], mdl[2][5:0], mdl[1]});
      check_all("R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule